// File: doc/BRIEF.md
# Self-Loop Clock-Suppressed Moore Controller

This block is a four-state Moore controller with two primary inputs. Its state register and its registered Moore outputs do not run on the free clock. They run on a derived clock that is switched off for any cycle in which the present state and the present inputs select a self-loop arc. In such a cycle the register would only reload the value it already holds, so skipping the edge leaves the state sequence exactly as it would be without gating.

An activation stage compares the computed next state with the present state. Its enable is captured by a latch that is transparent while the clock is low. The register clock is formed as the AND of the free clock and the latched enable, so a change of enable in the low phase cannot produce a runt pulse.

A synchronous active-high reset forces the enable high, so the register always receives the edge that clears it. A saturating counter on the free clock counts the suppressed edges, and the latched enable is brought out for observation.

Top module: `gated_moore_fsm`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next values are `moore_out` = 4'b0001 (idle), `gated_cnt` = 0, and `clk_en_dbg` reads 1 during the cycle.
- R2: States are encoded idle=0, arm=1, run=2, drain=3. Transitions on input `in_x`:
  - idle goes to arm when `in_x[0]`=1, otherwise stays.
  - arm goes to run on 2'b11 and to idle on 2'b00, otherwise stays.
  - run stays when `in_x[1]`=1, otherwise goes to drain.
  - drain goes to idle on 2'b10 and to run on 2'b01, otherwise stays.
- R3: `moore_out` is one-hot, with bit i set exactly when the state is i. It depends on the state only.
- R4: `clk_en_dbg` is 0 during a cycle exactly when reset is low and the present state and input select a self-loop. Otherwise it is 1.
- R5: In a cycle with `clk_en_dbg` = 0, `moore_out` does not change at the following edge.
- R6: Each cycle with `clk_en_dbg` = 0 adds one to `gated_cnt`. A cycle with `clk_en_dbg` = 1 leaves `gated_cnt` unchanged.
- R7: `gated_cnt` saturates at its all-ones value.
- R8: The state sequence equals that of an ungated machine fed the same inputs. This includes a reset raised while the machine is parked in a self-loop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| in_x | input | IN_W (2) | Primary inputs |
| moore_out | output | NUM_ST (4) | Registered one-hot Moore outputs |
| clk_en_dbg | output | 1 | Latched clock enable of the state register |
| gated_cnt | output | CNT_W | Saturating count of suppressed edges |

## Verification
The checker watches the following on every cycle:
- that the outputs are one-hot;
- that they hold across every edge with a low enable;
- that the counter steps by one on suppressed edges, stays put on enabled edges and saturates;
- that reset clears everything.

Whether the enable is low exactly on self-loop arcs, and whether the transition table and state sequence are right, can only be shown by the bench. Its behavioural ungated model predicts the enable, outputs and counter each cycle across walks through every arc, a saturation run with a narrow counter, and a reset raised mid-loop.

// File: rtl/gfsm_pkg.sv
package gfsm_pkg;
  localparam int IN_W   = 2;
  localparam int NUM_ST = 4;
  localparam int ST_W   = $clog2(NUM_ST);

  typedef enum logic [ST_W-1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_RUN   = 2'd2,
    ST_DRAIN = 2'd3
  } gfsm_state_e;
endpackage

// File: rtl/gfsm_next.sv
module gfsm_next
  import gfsm_pkg::*;
(
  input  gfsm_state_e       cur,
  input  logic [IN_W-1:0]   x,
  output gfsm_state_e       nxt
);
  always_comb begin
    nxt = cur;
    unique case (cur)
      ST_IDLE:  if (x[0]) nxt = ST_ARM;
      ST_ARM: begin
        if (x == 2'b11)      nxt = ST_RUN;
        else if (x == 2'b00) nxt = ST_IDLE;
      end
      ST_RUN:   if (!x[1]) nxt = ST_DRAIN;
      ST_DRAIN: begin
        if (x == 2'b10)      nxt = ST_IDLE;
        else if (x == 2'b01) nxt = ST_RUN;
      end
      default:  nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/gfsm_activation.sv
module gfsm_activation
  import gfsm_pkg::*;
(
  input  logic        rst,
  input  gfsm_state_e cur,
  input  gfsm_state_e nxt,
  output logic        en
);
  // Reset always needs an edge; otherwise only a real state change does.
  assign en = rst | (nxt != cur);
endmodule

// File: rtl/gfsm_clk_gate.sv
module gfsm_clk_gate (
  input  logic clk,
  input  logic en,
  output logic en_lat,
  output logic gclk
);
  // Transparent while clk is low, so en_lat is frozen for the whole high phase.
  always_latch begin
    if (!clk) en_lat = en;
  end
  assign gclk = clk & en_lat;
endmodule

// File: rtl/gfsm_state_reg.sv
module gfsm_state_reg
  import gfsm_pkg::*;
(
  input  logic              gclk,
  input  logic              rst,
  input  gfsm_state_e       nxt,
  output gfsm_state_e       cur,
  output logic [NUM_ST-1:0] out_q
);
  logic [NUM_ST-1:0] out_d;

  for (genvar g = 0; g < NUM_ST; g++) begin : g_dec
    assign out_d[g] = (nxt == gfsm_state_e'(g));
  end

  always_ff @(posedge gclk) begin
    if (rst) begin
      cur   <= ST_IDLE;
      out_q <= NUM_ST'(1);
    end else begin
      cur   <= nxt;
      out_q <= out_d;
    end
  end
endmodule

// File: rtl/gfsm_skip_counter.sv
module gfsm_skip_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_lat,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst)                          cnt <= '0;
    else if (!en_lat && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/gated_moore_fsm.sv
module gated_moore_fsm
  import gfsm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IN_W-1:0]   in_x,
  output logic [NUM_ST-1:0] moore_out,
  output logic              clk_en_dbg,
  output logic [CNT_W-1:0]  gated_cnt
);
  gfsm_state_e cur_st, nxt_st;
  logic        en_raw, en_lat, gclk;

  gfsm_next u_next (.cur(cur_st), .x(in_x), .nxt(nxt_st));

  gfsm_activation u_act (.rst(rst), .cur(cur_st), .nxt(nxt_st), .en(en_raw));

  gfsm_clk_gate u_gate (.clk(clk), .en(en_raw), .en_lat(en_lat), .gclk(gclk));

  gfsm_state_reg u_reg (
    .gclk(gclk), .rst(rst), .nxt(nxt_st), .cur(cur_st), .out_q(moore_out)
  );

  gfsm_skip_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en_lat(en_lat), .cnt(gated_cnt)
  );

  assign clk_en_dbg = en_lat;
endmodule

// File: rtl/gated_moore_fsm_chk.sv
module gated_moore_fsm_chk #(
  parameter int CNT_W = 16,
  parameter int NUM_ST = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_ST-1:0] moore_out,
  input logic              clk_en_dbg,
  input logic [CNT_W-1:0]  gated_cnt
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (moore_out == NUM_ST'(1) && gated_cnt == '0));

  assert_onehot_out_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(moore_out) == 1);

  assert_frozen_when_gated_R5: assert property (@(posedge clk) disable iff (rst)
    !clk_en_dbg |=> $stable(moore_out));

  assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_dbg && gated_cnt != CMAX) |=> gated_cnt == $past(gated_cnt) + 1'b1);

  assert_count_hold_R6: assert property (@(posedge clk) disable iff (rst)
    clk_en_dbg |=> $stable(gated_cnt));

  assert_count_sat_R7: assert property (@(posedge clk) disable iff (rst)
    (gated_cnt == CMAX) |=> gated_cnt == CMAX);
endmodule

bind gated_moore_fsm gated_moore_fsm_chk #(.CNT_W(CNT_W), .NUM_ST(gfsm_pkg::NUM_ST)) u_chk (
  .clk(clk), .rst(rst), .moore_out(moore_out),
  .clk_en_dbg(clk_en_dbg), .gated_cnt(gated_cnt)
);

// File: tb/gated_moore_fsm_tb_top.sv
`timescale 1ns/1ps
module gated_moore_fsm_tb_top;
  localparam int CW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    in_x = 2'b00;
  logic [3:0]    moore_out;
  logic          clk_en_dbg;
  logic [CW-1:0] gated_cnt;

  int n_chk = 0;
  int n_bad = 0;
  int m_st  = 0;
  int m_cnt = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  gated_moore_fsm #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .in_x(in_x),
    .moore_out(moore_out), .clk_en_dbg(clk_en_dbg), .gated_cnt(gated_cnt)
  );

  // Ungated behavioural reference of the transition table.
  function automatic int ref_next(int s, logic [1:0] x);
    case (s)
      0: return x[0] ? 1 : 0;
      1: return (x == 2'b11) ? 2 : (x == 2'b00) ? 0 : 1;
      2: return x[1] ? 2 : 3;
      default: return (x == 2'b10) ? 0 : (x == 2'b01) ? 2 : 3;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive in the low phase, check enable before the edge, outputs after it.
  task automatic step(logic [1:0] x, logic r);
    int nx;
    @(negedge clk);
    in_x = x;
    rst  = r;
    #1.5;
    nx = ref_next(m_st, x);
    if (r) check("R1 enable", int'(clk_en_dbg), 1);
    else   check("R4 enable", int'(clk_en_dbg), (nx != m_st) ? 1 : 0);
    @(posedge clk);
    if (r) begin
      m_st = 0;
      m_cnt = 0;
    end else begin
      if (nx == m_st && m_cnt < CMAX) m_cnt++;
      m_st = nx;
    end
    #0.5;
    check(r ? "R1 out" : "R2/R3/R5/R8 out", int'(moore_out), 1 << m_st);
    check(r ? "R1 cnt" : "R6/R7 cnt", int'(gated_cnt), m_cnt);
  endtask

  initial begin
    #20000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(2'b00, 1'b1);
    step(2'b00, 1'b1);                // R1 reset state
    // R2: every arc, including self-loops (R4/R5/R6)
    step(2'b00, 1'b0);                // idle loop
    step(2'b10, 1'b0);                // idle loop
    step(2'b01, 1'b0);                // idle->arm
    step(2'b01, 1'b0);                // arm loop
    step(2'b00, 1'b0);                // arm->idle
    step(2'b11, 1'b0);                // idle->arm
    step(2'b11, 1'b0);                // arm->run
    step(2'b10, 1'b0);                // run loop
    step(2'b11, 1'b0);                // run loop
    step(2'b01, 1'b0);                // run->drain
    step(2'b00, 1'b0);                // drain loop
    step(2'b01, 1'b0);                // drain->run
    step(2'b00, 1'b0);                // run->drain
    step(2'b11, 1'b0);                // drain loop
    step(2'b10, 1'b0);                // drain->idle
    // R7: park in a loop long enough to saturate the narrow counter
    for (int i = 0; i < 20; i++) step(2'b00, 1'b0);
    // R8: reset while parked in a self-loop
    step(2'b01, 1'b0);
    step(2'b11, 1'b0);
    step(2'b11, 1'b0);                // run loop
    step(2'b11, 1'b1);                // reset raised mid-loop
    // R8: pseudo-random walk versus the ungated model
    for (int i = 0; i < 200; i++) step(2'((i * 7 + i / 3) % 4), 1'b0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule